// File: doc/BRIEF.md
# Square-Wave Beeper with Per-Pin Pulse-Density Volume

This peripheral produces a square-wave tone for a set number of milliseconds and drives it onto four output pins meant for an external nonlinear resistor ladder. The pitch comes from a phase accumulator. The host writes a phase increment, and the accumulator's top bit is the square wave. The host picks the note and volume in software, converts them to an increment and four gain codes, and writes them into the block.

Volume is set per pin. Each pin has its own free-running 4-bit pulse-density counter. While the tone is sounding and the square wave is high, a pin is driven for as many counts out of every sixteen as its gain code. When the square wave is low, all pins stay low. After the ladder and an RC filter, mixing the four pin densities gives a fine, roughly logarithmic gain range. Note length is counted in milliseconds. A prescaler derived from the clock-frequency parameter produces the millisecond tick. Writing the length starts the note.

Top module: `tone_beeper`

## Requirements
- R1: A request (cycle and strobe high while acknowledge is low) is acknowledged on the next clock edge. The acknowledge is a one-cycle pulse. Read data is valid in the cycle the acknowledge is high.
- R2: Word address 0 holds the 24-bit phase increment in bits 23:0. Address 1 holds four 4-bit gain codes: pin 0 in bits 3:0, pin 1 in bits 7:4, pin 2 in bits 11:8 and pin 3 in bits 15:12. Address 2 holds the 8-bit duration in bits 7:0, and bit 8 reads 1 while a note is sounding. Reads return the written values with all unused bits zero.
- R3: The 24-bit phase accumulator adds the increment on every clock. Its bit 23 is the square wave.
- R4: Each pin has a 4-bit counter that starts at 0 after reset and advances by one every clock. While a note sounds and the square wave is high, pin i is high exactly when its counter is below gain code i.
- R5: While the square wave is low, all four pins are low.
- R6: A write to address 2 clears the millisecond count and the prescaler. The note then sounds for duration × (CLK_HZ/1000) clocks. After that the busy bit reads 0 and all pins stay low until the next write to address 2.
- R7: A duration of 0 produces no sound, and the busy bit reads 0.
- R8: A gain of 0 keeps its pin low at all times. A gain of 15 drives its pin high in 15 of every 16 clocks while the square wave is high.
- R9: After reset, all registers read 0, the block is idle and the pins are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cyc | input | 1 | Bus cycle |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Write enable |
| bus_adr | input | 2 | Word address |
| bus_dat_w | input | 32 | Write data |
| bus_dat_r | output | 32 | Read data |
| bus_ack | output | 1 | Acknowledge |
| tone_pins | output | 4 | Ladder drive pins |

## Verification
A write takes effect on the edge that raises the acknowledge. Read data and the acknowledge appear one clock after the request. The pins are built only from registered state, so they change right after each edge. The bench keeps a reference model that updates on the same edges from the committed writes. A monitor compares the pins with the model at every falling edge. Each read's expected value is computed from the model's state just before the request edge and queued, and it is compared when the acknowledge is seen at the next falling edge.

// File: rtl/tone_beeper.sv
module tone_beeper #(
  parameter int CLK_HZ  = 1_000_000,
  parameter int PHASE_W = 24,
  parameter int GAIN_W  = 4,
  parameter int PINS    = 4,
  parameter int DUR_W   = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cyc,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [1:0]        bus_adr,
  input  logic [DATA_W-1:0] bus_dat_w,
  output logic [DATA_W-1:0] bus_dat_r,
  output logic              bus_ack,
  output logic [PINS-1:0]   tone_pins
);
  localparam int TICK  = CLK_HZ / 1000;
  localparam int PRE_W = (TICK > 1) ? $clog2(TICK) : 1;
  localparam int GB_W  = PINS * GAIN_W;

  logic [PHASE_W-1:0] inc_q, acc_q;
  logic [GB_W-1:0]    gain_q;
  logic [DUR_W-1:0]   dur_q, ms_q;
  logic [PRE_W-1:0]   pre_q;
  logic               req, wr, wr_dur, busy, sq;
  logic               unused_dat;

  assign req    = bus_cyc & bus_stb & ~bus_ack;
  assign wr     = req & bus_we;
  assign wr_dur = wr & (bus_adr == 2'd2);
  assign busy   = (ms_q != dur_q);
  assign sq     = acc_q[PHASE_W-1];
  assign unused_dat = ^bus_dat_w[DATA_W-1:PHASE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_dat_r <= '0;
      inc_q     <= '0;
      gain_q    <= '0;
    end else begin
      bus_ack <= req;
      if (req) begin
        case (bus_adr)
          2'd0:    bus_dat_r <= DATA_W'(inc_q);
          2'd1:    bus_dat_r <= DATA_W'(gain_q);
          2'd2:    bus_dat_r <= DATA_W'({busy, dur_q});
          default: bus_dat_r <= '0;
        endcase
      end
      if (wr && bus_adr == 2'd0) inc_q  <= bus_dat_w[PHASE_W-1:0];
      if (wr && bus_adr == 2'd1) gain_q <= bus_dat_w[GB_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_q + inc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dur_q <= '0;
      ms_q  <= '0;
      pre_q <= '0;
    end else if (wr_dur) begin
      dur_q <= bus_dat_w[DUR_W-1:0];
      ms_q  <= '0;
      pre_q <= '0;
    end else if (busy) begin
      if (pre_q == PRE_W'(TICK - 1)) begin
        pre_q <= '0;
        ms_q  <= ms_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [GAIN_W-1:0] cnt_q;
    logic [GAIN_W-1:0] lvl;
    assign lvl = gain_q[i*GAIN_W +: GAIN_W];
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
    end
    assign tone_pins[i] = busy & sq & (cnt_q < lvl);

    // R8
    zero_gain_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl == '0) |-> !tone_pins[i]);
  end

  // R1
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);
  // R1
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_stb && !bus_ack) |=> bus_ack);
  // R6
  dur_write_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dur |=> (ms_q == '0 && pre_q == '0));
  // R6
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_dur) |=> (!busy && tone_pins == '0));
  // R5
  low_square_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sq |-> (tone_pins == '0));
  // R6
  ms_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_dur) |=> (ms_q <= dur_q));
endmodule

// File: tb/tone_beeper_bench.sv
module tone_beeper_bench;
  localparam int CLK_HZ = 20_000;
  localparam int TICK   = CLK_HZ / 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_adr = '0;
  logic [31:0] bus_dat_w = '0;
  logic [31:0] bus_dat_r;
  logic        bus_ack;
  logic [3:0]  tone_pins;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  tone_beeper #(.CLK_HZ(CLK_HZ)) u_tone_beeper (
    .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
    .bus_we(bus_we), .bus_adr(bus_adr), .bus_dat_w(bus_dat_w),
    .bus_dat_r(bus_dat_r), .bus_ack(bus_ack), .tone_pins(tone_pins));

  // reference model from the requirements
  logic [23:0] m_inc, m_acc;
  logic [15:0] m_gain;
  logic [7:0]  m_dur, m_ms;
  int          m_pre;
  logic [3:0]  m_cnt;
  logic        m_busy;
  assign m_busy = (m_ms != m_dur);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_inc <= '0; m_acc <= '0; m_gain <= '0; m_dur <= '0;
      m_ms <= '0; m_pre <= 0; m_cnt <= '0;
    end else begin
      m_acc <= m_acc + m_inc;
      m_cnt <= m_cnt + 4'd1;
      if (bus_cyc && bus_stb && bus_we && !bus_ack && bus_adr == 2'd0) m_inc <= bus_dat_w[23:0];
      if (bus_cyc && bus_stb && bus_we && !bus_ack && bus_adr == 2'd1) m_gain <= bus_dat_w[15:0];
      if (bus_cyc && bus_stb && bus_we && !bus_ack && bus_adr == 2'd2) begin
        m_dur <= bus_dat_w[7:0]; m_ms <= '0; m_pre <= 0;
      end else if (m_busy) begin
        if (m_pre == TICK - 1) begin m_pre <= 0; m_ms <= m_ms + 8'd1; end
        else m_pre <= m_pre + 1;
      end
    end
  end

  // scoreboard for reads
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_adr = a; bus_dat_w = d;
    @(negedge clk); #1;
    check(bus_ack == 1'b1, "R1 write ack", {31'd0, bus_ack}, 32'd1);
    bus_cyc = 0; bus_stb = 0; bus_we = 0;
    @(negedge clk);
    check(bus_ack == 1'b0, "R1 ack pulse", {31'd0, bus_ack}, 32'd0);
  endtask

  task automatic bus_read(input logic [1:0] a, input string req);
    logic [31:0] e;
    @(negedge clk); #1;
    case (a)
      2'd0: e = {8'd0, m_inc};
      2'd1: e = {16'd0, m_gain};
      2'd2: e = {23'd0, m_busy, m_dur};
      default: e = '0;
    endcase
    exp_q.push_back(e); tag_q.push_back(req);
    bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_adr = a;
    @(negedge clk); #1;
    bus_cyc = 0; bus_stb = 0;
  endtask

  task automatic read_expect(input logic [1:0] a, input logic [31:0] v, input string req);
    bus_read(a, req);
    @(negedge clk);
    check(bus_dat_r == v, {req, " direct"}, bus_dat_r, v);
  endtask

  // read monitor
  always @(negedge clk) begin
    if (rst_n && bus_ack && !bus_we && exp_q.size() > 0) begin
      logic [31:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      check(bus_dat_r == e, t, bus_dat_r, e);
    end
  end

  // pin monitor
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] ep;
      for (int i = 0; i < 4; i++)
        ep[i] = m_busy & m_acc[23] & (m_cnt < m_gain[i*4 +: 4]);
      if (!m_busy)
        check(tone_pins == ep, "R6 pins idle", {28'd0, tone_pins}, {28'd0, ep});
      else if (!m_acc[23])
        check(tone_pins == ep, "R5 square low", {28'd0, tone_pins}, {28'd0, ep});
      else
        check(tone_pins == ep, "R4 R8 density", {28'd0, tone_pins}, {28'd0, ep});
    end
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    read_expect(2'd0, 32'd0, "R9 inc");
    read_expect(2'd1, 32'd0, "R9 gain");
    read_expect(2'd2, 32'd0, "R9 status");
    // R2 readback, R3 tone
    bus_write(2'd0, 32'hFF10_0000);
    bus_write(2'd1, 32'hABCD_F730);
    read_expect(2'd0, 32'h0010_0000, "R2 inc");
    read_expect(2'd1, 32'h0000_F730, "R2 gain");
    // R6 note of 10 ms
    bus_write(2'd2, 32'd10);
    repeat (50) @(negedge clk);
    read_expect(2'd2, 32'h0000_010A, "R6 busy");
    repeat (10 * TICK) @(negedge clk);
    read_expect(2'd2, 32'h0000_000A, "R6 done");
    repeat (40) @(negedge clk);
    // R8 full gain, odd increment R3
    bus_write(2'd1, 32'h0000_FFFF);
    bus_write(2'd0, 32'h002A_AAAB);
    bus_write(2'd2, 32'd4);
    repeat (30) @(negedge clk);
    bus_write(2'd2, 32'd3);   // R6 restart mid note
    repeat (2 * TICK) @(negedge clk);
    read_expect(2'd2, 32'h0000_0103, "R6 restart busy");
    repeat (2 * TICK) @(negedge clk);
    bus_read(2'd2, "R6 restart done");
    // R8 zero gain on all pins
    bus_write(2'd1, 32'h0000_0000);
    bus_write(2'd2, 32'd5);
    repeat (6 * TICK) @(negedge clk);
    // R7 zero duration
    bus_write(2'd1, 32'h0000_5A3C);
    bus_write(2'd2, 32'd0);
    read_expect(2'd2, 32'h0000_0000, "R7 idle");
    repeat (60) @(negedge clk);
    // R5 slow tone: long low halves
    bus_write(2'd0, 32'h0004_0000);
    bus_write(2'd2, 32'd8);
    repeat (9 * TICK) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R1 all reads acked", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule